// File: doc/BRIEF.md
# Shared-Stage Two-Phase Converter Timing Generator

This block produces the two non-overlapping phase windows and the sub-phase strobes for a pipelined converter front end. In that front end two pipeline stages take turns using one comparator bank and one residue amplifier. It runs from a fast tick clock. One phase window lasts `PHASE_TICKS` ticks, which is one period of the external clock. One full sample period is therefore two phase windows, so the external clock runs at twice the sample rate. Each window is active for `PHASE_TICKS - GAP_TICKS` ticks and then idles for `GAP_TICKS` ticks. This idle time is the dead time between the two phases.

Each active window is cut into halves. In the first half the comparator bank samples its references and the amplifier auto-zeroes. In the second half the comparators convert and the amplifier amplifies. In window A (`q1_o`) the bank looks at stage 1 with a reduced set of comparators, and stage 1 samples the input. In the same window the amplifier serves the stage 2 residue, which goes on to the final stage. In window B (`q2_o`) the bank looks at stage 2 with every comparator enabled. The amplifier serves the stage 1 residue, and stage 2 samples the result. Every output is a registered level.

Top module: `conv_phase_gen`

## Requirements
- R1: `q1_o` and `q2_o` are never high in the same tick.
- R2: After either phase window falls, both windows stay low for exactly `GAP_TICKS` ticks before the other window rises.
- R3: Each window is high for `PHASE_TICKS - GAP_TICKS` consecutive ticks, and the two windows alternate with a period of `2*PHASE_TICKS` ticks.
- R4: `ref_samp_o` and `az_o` are high in the first half of every active window (ticks 0 to H-1, where H = (PHASE_TICKS-GAP_TICKS)/2). `cmp_conv_o` and `amp_o` are high in the rest of the active window. All four are low in the gap.
- R5: `in_samp1_o` and `sel_s1_o` follow window A exactly. `in_samp2_o` and `sel_s2_o` follow window B exactly.
- R6: `amp_res2_o` is high only in the second half of window A. `amp_res1_o` is high only in the second half of window B.
- R7: `cmp_en_o` has bits 0 to `S1_CMP-1` set (and no others) during window A, all `NUM_CMP` bits set during window B, and all bits clear in the gap.
- R8: While `rst_n` is low, every output is 0. After release every output stays 0 until window A rises on the `GAP_TICKS`-th rising edge, so the first window A is always complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock, `PHASE_TICKS` ticks per external-clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| q1_o | output | 1 | Phase window A |
| q2_o | output | 1 | Phase window B |
| in_samp1_o | output | 1 | Stage 1 input sampling |
| in_samp2_o | output | 1 | Stage 2 sampling of amplified residue |
| ref_samp_o | output | 1 | Comparator reference sampling |
| cmp_conv_o | output | 1 | Comparator conversion |
| sel_s1_o | output | 1 | Comparator bank input routed to stage 1 |
| sel_s2_o | output | 1 | Comparator bank input routed to stage 2 |
| az_o | output | 1 | Amplifier auto-zero |
| amp_o | output | 1 | Amplifier amplify |
| amp_res1_o | output | 1 | Amplifier working on stage 1 residue |
| amp_res2_o | output | 1 | Amplifier working on stage 2 residue |
| cmp_en_o | output | NUM_CMP | Per-comparator enable |

## Verification
The bench targets the window edges. A design with an off-by-one gap would raise window B in the same tick that A falls, or one tick late. A wrong half boundary would leave reference sampling and conversion overlapping, or leave a tick with neither. It also checks the first window after reset and after a second reset in the middle of window A. A counter that restarts at tick zero of window A would emit a shortened or immediate first window instead of idling through the gap. Swapped residue routing or a mis-sized comparator mask shows up as the wrong stage flag or the wrong population of `cmp_en_o` in a given window.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    typedef struct packed {
        logic q1;
        logic q2;
        logic samp1;
        logic samp2;
        logic refs;
        logic conv;
        logic sel1;
        logic sel2;
        logic az;
        logic amp;
        logic res1;
        logic res2;
    } strobe_t;

endpackage

// File: rtl/cpg_tick_counter.sv
module cpg_tick_counter
    import cpg_pkg::*;
#(
    parameter int PHASE_TICKS = 10,
    parameter int GAP_TICKS   = 2,
    localparam int CNT_W      = $clog2(PHASE_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output phase_e           ph_nxt_o
);

    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(PHASE_TICKS - 1);
    // Reset parks the counter at the start of the gap of window B,
    // so the first window A that follows is complete.
    localparam logic [CNT_W-1:0] PARK_TICK = CNT_W'(PHASE_TICKS - GAP_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        phase_e           ph;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST_TICK) begin
            st_d.cnt = '0;
            st_d.ph  = (st_q.ph == PH_A) ? PH_B : PH_A;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= PARK_TICK;
            st_q.ph  <= PH_B;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_nxt_o = st_d.cnt;
    assign ph_nxt_o  = st_d.ph;

endmodule

// File: rtl/cpg_window_decode.sv
module cpg_window_decode
    import cpg_pkg::*;
#(
    parameter int PHASE_TICKS = 10,
    parameter int GAP_TICKS   = 2,
    localparam int CNT_W      = $clog2(PHASE_TICKS)
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  phase_e           ph_i,
    output strobe_t          strb_o
);

    localparam int ACT_TICKS  = PHASE_TICKS - GAP_TICKS;
    localparam int HALF_TICKS = ACT_TICKS / 2;
    localparam logic [CNT_W-1:0] ACT_END  = CNT_W'(ACT_TICKS);
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF_TICKS);

    logic active, early, late, in_a, in_b;

    always_comb begin
        active = (cnt_i < ACT_END);
        early  = active && (cnt_i < HALF_END);
        late   = active && !early;
        in_a   = active && (ph_i == PH_A);
        in_b   = active && (ph_i == PH_B);

        strb_o.q1    = in_a;
        strb_o.q2    = in_b;
        strb_o.samp1 = in_a;
        strb_o.samp2 = in_b;
        strb_o.refs  = early;
        strb_o.conv  = late;
        strb_o.sel1  = in_a;
        strb_o.sel2  = in_b;
        strb_o.az    = early;
        strb_o.amp   = late;
        strb_o.res1  = late && (ph_i == PH_B);
        strb_o.res2  = late && (ph_i == PH_A);
    end

endmodule

// File: rtl/cpg_cmp_mask.sv
module cpg_cmp_mask #(
    parameter int NUM_CMP = 14,
    parameter int S1_CMP  = 6
) (
    input  logic               sel1_i,
    input  logic               sel2_i,
    output logic [NUM_CMP-1:0] en_o
);

    for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
        if (gi < S1_CMP) begin : g_shared
            assign en_o[gi] = sel1_i | sel2_i;
        end else begin : g_wide
            assign en_o[gi] = sel2_i;
        end
    end

endmodule

// File: rtl/conv_phase_gen.sv
module conv_phase_gen
    import cpg_pkg::*;
#(
    parameter int PHASE_TICKS = 10,
    parameter int GAP_TICKS   = 2,
    parameter int NUM_CMP     = 14,
    parameter int S1_CMP      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               q1_o,
    output logic               q2_o,
    output logic               in_samp1_o,
    output logic               in_samp2_o,
    output logic               ref_samp_o,
    output logic               cmp_conv_o,
    output logic               sel_s1_o,
    output logic               sel_s2_o,
    output logic               az_o,
    output logic               amp_o,
    output logic               amp_res1_o,
    output logic               amp_res2_o,
    output logic [NUM_CMP-1:0] cmp_en_o
);

    localparam int CNT_W = $clog2(PHASE_TICKS);

    typedef struct packed {
        strobe_t            strb;
        logic [NUM_CMP-1:0] en;
    } out_t;

    logic [CNT_W-1:0]   cnt_nxt;
    phase_e             ph_nxt;
    strobe_t            strb_nxt;
    logic [NUM_CMP-1:0] en_nxt;
    out_t               out_d, out_q;

    cpg_tick_counter #(
        .PHASE_TICKS(PHASE_TICKS),
        .GAP_TICKS  (GAP_TICKS)
    ) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_nxt_o(cnt_nxt),
        .ph_nxt_o (ph_nxt)
    );

    cpg_window_decode #(
        .PHASE_TICKS(PHASE_TICKS),
        .GAP_TICKS  (GAP_TICKS)
    ) i_decode (
        .cnt_i (cnt_nxt),
        .ph_i  (ph_nxt),
        .strb_o(strb_nxt)
    );

    cpg_cmp_mask #(
        .NUM_CMP(NUM_CMP),
        .S1_CMP (S1_CMP)
    ) i_mask (
        .sel1_i(strb_nxt.sel1),
        .sel2_i(strb_nxt.sel2),
        .en_o  (en_nxt)
    );

    always_comb begin
        out_d.strb = strb_nxt;
        out_d.en   = en_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign q1_o       = out_q.strb.q1;
    assign q2_o       = out_q.strb.q2;
    assign in_samp1_o = out_q.strb.samp1;
    assign in_samp2_o = out_q.strb.samp2;
    assign ref_samp_o = out_q.strb.refs;
    assign cmp_conv_o = out_q.strb.conv;
    assign sel_s1_o   = out_q.strb.sel1;
    assign sel_s2_o   = out_q.strb.sel2;
    assign az_o       = out_q.strb.az;
    assign amp_o      = out_q.strb.amp;
    assign amp_res1_o = out_q.strb.res1;
    assign amp_res2_o = out_q.strb.res2;
    assign cmp_en_o   = out_q.en;

endmodule

// File: rtl/conv_phase_gen_chk.sv
module conv_phase_gen_chk #(
    parameter int NUM_CMP = 14,
    parameter int S1_CMP  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               q1_o,
    input logic               q2_o,
    input logic               in_samp1_o,
    input logic               in_samp2_o,
    input logic               ref_samp_o,
    input logic               cmp_conv_o,
    input logic               sel_s1_o,
    input logic               sel_s2_o,
    input logic               az_o,
    input logic               amp_o,
    input logic               amp_res1_o,
    input logic               amp_res2_o,
    input logic [NUM_CMP-1:0] cmp_en_o
);

    logic seen_a_q;
    logic any_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_a_q <= 1'b0;
        else if (q1_o) seen_a_q <= 1'b1;
    end

    assign any_out = q1_o | q2_o | in_samp1_o | in_samp2_o | ref_samp_o |
                     cmp_conv_o | sel_s1_o | sel_s2_o | az_o | amp_o |
                     amp_res1_o | amp_res2_o | (|cmp_en_o);

    p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(q1_o && q2_o));

    p_gap_after_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q1_o) |-> !q2_o);

    p_gap_after_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q2_o) |-> !q1_o);

    p_halves_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_samp_o && cmp_conv_o) && !(az_o && amp_o));

    p_ref_then_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_samp_o) |-> cmp_conv_o);

    p_select_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s1_o == q1_o) && (sel_s2_o == q2_o));

    p_res2_in_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        amp_res2_o |-> (q1_o && amp_o));

    p_res1_in_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        amp_res1_o |-> (q2_o && amp_o));

    p_mask_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q1_o |-> ($countones(cmp_en_o) == S1_CMP && cmp_en_o[0]));

    p_mask_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q2_o |-> ($countones(cmp_en_o) == NUM_CMP));

    p_mask_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(q1_o || q2_o) |-> (cmp_en_o == '0));

    p_quiet_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_a_q && !q1_o) |-> !any_out);

endmodule

bind conv_phase_gen conv_phase_gen_chk #(
    .NUM_CMP(NUM_CMP),
    .S1_CMP (S1_CMP)
) i_conv_phase_gen_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q1_o      (q1_o),
    .q2_o      (q2_o),
    .in_samp1_o(in_samp1_o),
    .in_samp2_o(in_samp2_o),
    .ref_samp_o(ref_samp_o),
    .cmp_conv_o(cmp_conv_o),
    .sel_s1_o  (sel_s1_o),
    .sel_s2_o  (sel_s2_o),
    .az_o      (az_o),
    .amp_o     (amp_o),
    .amp_res1_o(amp_res1_o),
    .amp_res2_o(amp_res2_o),
    .cmp_en_o  (cmp_en_o)
);

// File: tb/test_conv_phase_gen.sv
`timescale 1ns/1ps
module test_conv_phase_gen;

    localparam int PT   = 10;
    localparam int GT   = 2;
    localparam int NC   = 14;
    localparam int S1   = 6;
    localparam int ACT  = PT - GT;
    localparam int HALF = ACT / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          q1, q2, s1, s2, rf, cv, se1, se2, az, amp, r1, r2;
    logic [NC-1:0] en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    conv_phase_gen #(
        .PHASE_TICKS(PT), .GAP_TICKS(GT), .NUM_CMP(NC), .S1_CMP(S1)
    ) i_conv_phase_gen (
        .clk(clk), .rst_n(rst_n),
        .q1_o(q1), .q2_o(q2), .in_samp1_o(s1), .in_samp2_o(s2),
        .ref_samp_o(rf), .cmp_conv_o(cv), .sel_s1_o(se1), .sel_s2_o(se2),
        .az_o(az), .amp_o(amp), .amp_res1_o(r1), .amp_res2_o(r2),
        .cmp_en_o(en)
    );

    task automatic chk(input string tag, input string nm,
                       input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, nm, got, exp, $time);
        end
    endtask

    // Reference: t rising edges since reset release. The timeline starts in the
    // gap of window B, GT ticks before window A begins.
    task automatic check_model(input int t);
        int    g, c;
        bit    pa, pb, act, early, late;
        string tq;
        g     = t + 2 * PT - GT;
        c     = g % PT;
        pa    = ((g / PT) % 2) == 0;
        pb    = !pa;
        act   = c < ACT;
        early = act && (c < HALF);
        late  = act && !early;
        tq    = (t <= GT) ? "R8" : "R3";
        chk(tq,   "q1", 32'(q1), 32'(act && pa));
        chk(tq,   "q2", 32'(q2), 32'(act && pb));
        chk("R4", "ref_samp", 32'(rf), 32'(early));
        chk("R4", "az", 32'(az), 32'(early));
        chk("R4", "conv", 32'(cv), 32'(late));
        chk("R4", "amp", 32'(amp), 32'(late));
        chk("R5", "samp1", 32'(s1), 32'(act && pa));
        chk("R5", "sel1", 32'(se1), 32'(act && pa));
        chk("R5", "samp2", 32'(s2), 32'(act && pb));
        chk("R5", "sel2", 32'(se2), 32'(act && pb));
        chk("R6", "res1", 32'(r1), 32'(late && pb));
        chk("R6", "res2", 32'(r2), 32'(late && pa));
        chk("R7", "cmp_en", 32'(en),
            (act && pa) ? 32'((1 << S1) - 1) : (act && pb) ? 32'((1 << NC) - 1) : 32'd0);
        chk("R1", "overlap", 32'(q1 && q2), 32'd0);
    endtask

    task automatic check_all_zero(input string tag);
        chk(tag, "all outputs in reset",
            32'({q1, q2, s1, s2, rf, cv, se1, se2, az, amp, r1, r2, |en}), 32'd0);
    endtask

    // Run n ticks after a release, checking every tick and the gap lengths (R2).
    task automatic run_segment(input int n);
        int last_fall;
        bit prev_a, prev_b;
        last_fall = -1;
        prev_a    = 1'b0;
        prev_b    = 1'b0;
        check_model(0);
        for (int t = 1; t <= n; t++) begin
            @(posedge clk);
            @(negedge clk);
            check_model(t);
            if ((prev_a && !q1) || (prev_b && !q2)) last_fall = t;
            if (((!prev_a && q1) || (!prev_b && q2)) && last_fall >= 0)
                chk("R2", "gap ticks", 32'(t - last_fall), 32'(GT));
            prev_a = q1;
            prev_b = q2;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_all_zero("R8");
        rst_n = 1'b1;
        run_segment(6 * PT + 3);
        // Second reset, landing in the middle of window A.
        while (!(q1 && cv)) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_all_zero("R8");
        @(negedge clk);
        check_all_zero("R8");
        rst_n = 1'b1;
        run_segment(8 * PT);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule